// File: doc/BRIEF.md
# Vector Floating-Point Data-Class Tester

This block examines a 128-bit vector value and decides, for each floating-point element, whether that element falls into any of a chosen set of IEEE-754 data classes. A format select sets how the vector is split: either four single-precision elements or two double-precision elements. Each element is sorted into exactly one kind: NaN, infinity, zero, denormal or normal. Every kind except NaN and normal also carries its sign.

A 7-bit class-select mask says which sign-qualified kinds count as a hit. The mask is assembled from three separate select fields. The result has the same lane layout as the input. A lane that hits is filled with ones and a lane that misses is filled with zeros, so the output can be used directly as a lane mask by later vector logic.

Inputs are captured when `in_valid` is high. The result appears one clock later, together with `out_valid`.

Top module: `fpc_vec_tester`

## Requirements
- R1: With `fmt_dp` low, the vector is four single-precision lanes. Lane i occupies bits 32i+31..32i: the sign is bit 31 of the lane, the exponent is bits 30:23 and the fraction is bits 22:0. Each lane is tested on its own.
- R2: With `fmt_dp` high, the vector is two double-precision lanes. Lane i occupies bits 64i+63..64i: the sign is bit 63 of the lane, the exponent is bits 62:52 and the fraction is bits 51:0. Each lane is tested on its own.
- R3: Each result lane is all ones when the element's class is enabled in the mask, and all zeros otherwise. The result lane has the element's width.
- R4: An element with an all-ones exponent and a nonzero fraction is a NaN, whether quiet or signalling and of either sign. It hits exactly when mask bit 6 is set.
- R5: An element with an all-ones exponent and a zero fraction is an infinity. Positive infinity hits on mask bit 5 and negative infinity on mask bit 4.
- R6: An element with a zero exponent and a zero fraction is a zero. Positive zero hits on mask bit 3 and negative zero on mask bit 2.
- R7: An element with a zero exponent and a nonzero fraction is a denormal. Positive denormal hits on mask bit 1 and negative denormal on mask bit 0.
- R8: A normal finite element never hits, whatever the mask.
- R9: The mask is {`dc_top`, `dc_next`, `dc_low`}. `dc_top` is bit 6, `dc_next` is bit 5 and `dc_low` fills bits 4:0.
- R10: Inputs are sampled on a rising edge where `in_valid` is high. `result` and `out_valid` change on that edge. After an edge where `in_valid` is low, `out_valid` is low and `result` keeps its previous value.
- R11: A synchronous active-high `rst` clears `out_valid` and `result` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Qualifies the source vector and selects |
| fmt_dp | input | 1 | 0: four single-precision lanes, 1: two double-precision lanes |
| dc_top | input | 1 | Class-select mask bit 6 |
| dc_next | input | 1 | Class-select mask bit 5 |
| dc_low | input | 5 | Class-select mask bits 4:0 |
| src | input | 128 | Source vector |
| out_valid | output | 1 | Result is valid (one cycle after in_valid) |
| result | output | 128 | Per-lane all-ones / all-zeros class hit mask |

## Verification
A misclassified lane shows up one cycle after capture, as a lane of the wrong polarity. The bench exposes this by sweeping all 128 mask values against every class placed in every lane position, in both formats. A wrong priority between classes, or a swapped sign-qualified bit, appears for mask values that enable one class but not its neighbour. A lane-boundary error in the mode select gives a lane that is neither all ones nor all zeros, or a result that spills into the adjacent lane. A stale or stuck valid register shows up on the first idle cycle after a capture, and on the first cycle after reset.

// File: rtl/fpc_pkg.sv
package fpc_pkg;

  localparam int MASK_W    = 7;
  // mask bit positions; the position is what selects the class
  localparam int NAN_BIT   = 6;
  localparam int PINF_BIT  = 5;
  localparam int NINF_BIT  = 4;
  localparam int PZERO_BIT = 3;
  localparam int NZERO_BIT = 2;
  localparam int PDEN_BIT  = 1;
  localparam int NDEN_BIT  = 0;

  typedef enum logic [2:0] {
    KIND_NORMAL = 3'd0,
    KIND_NAN    = 3'd1,
    KIND_INF    = 3'd2,
    KIND_ZERO   = 3'd3,
    KIND_DENORM = 3'd4
  } fp_kind_e;

  typedef struct packed {
    logic     neg;
    fp_kind_e kind;
  } lane_class_t;

endpackage

// File: rtl/fpc_lane_classify.sv
module fpc_lane_classify
  import fpc_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int LANE_W = 1 + EXP_W + FRAC_W
) (
  input  logic [LANE_W-1:0] lane,
  output lane_class_t       cls
);

  logic [EXP_W-1:0]  exp_f;
  logic [FRAC_W-1:0] frac_f;
  logic exp_max, exp_min, frac_nz;
  logic f_nan, f_inf, f_zero, f_den;

  assign exp_f   = lane[LANE_W-2 -: EXP_W];
  assign frac_f  = lane[FRAC_W-1:0];
  assign exp_max = &exp_f;
  assign exp_min = ~|exp_f;
  assign frac_nz = |frac_f;

  // independent decodes, each from raw fields
  assign f_nan  = exp_max &  frac_nz;
  assign f_inf  = exp_max & ~frac_nz;
  assign f_zero = exp_min & ~frac_nz;
  assign f_den  = exp_min &  frac_nz;

  // fixed priority: NaN, infinity, zero, denormal
  always_comb begin
    cls.neg = lane[LANE_W-1];
    if (f_nan)       cls.kind = KIND_NAN;
    else if (f_inf)  cls.kind = KIND_INF;
    else if (f_zero) cls.kind = KIND_ZERO;
    else if (f_den)  cls.kind = KIND_DENORM;
    else             cls.kind = KIND_NORMAL;
  end

  // R4
  always_comb begin
    exclusive_kind_chk: assert ($onehot0({f_nan, f_inf, f_zero, f_den}));
  end

endmodule

// File: rtl/fpc_lane_match.sv
module fpc_lane_match
  import fpc_pkg::*;
#(
  parameter int LANE_W = 32
) (
  input  lane_class_t        cls,
  input  logic [MASK_W-1:0]  sel,
  output logic [LANE_W-1:0]  lane_out
);

  logic hit;

  always_comb begin
    unique case (cls.kind)
      KIND_NAN:    hit = sel[NAN_BIT];
      KIND_INF:    hit = cls.neg ? sel[NINF_BIT]  : sel[PINF_BIT];
      KIND_ZERO:   hit = cls.neg ? sel[NZERO_BIT] : sel[PZERO_BIT];
      KIND_DENORM: hit = cls.neg ? sel[NDEN_BIT]  : sel[PDEN_BIT];
      default:     hit = 1'b0;
    endcase
  end

  assign lane_out = {LANE_W{hit}};

  // R8
  always_comb begin
    normal_never_chk: assert (cls.kind != KIND_NORMAL || lane_out == '0);
  end

  // R4
  always_comb begin
    nan_select_chk: assert (cls.kind != KIND_NAN || lane_out == {LANE_W{sel[NAN_BIT]}});
  end

endmodule

// File: rtl/fpc_vec_tester.sv
module fpc_vec_tester
  import fpc_pkg::*;
#(
  parameter int VEC_W     = 128,
  parameter int SP_EXP_W  = 8,
  parameter int SP_FRAC_W = 23,
  parameter int DP_EXP_W  = 11,
  parameter int DP_FRAC_W = 52
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic             fmt_dp,
  input  logic             dc_top,
  input  logic             dc_next,
  input  logic [4:0]       dc_low,
  input  logic [VEC_W-1:0] src,
  output logic             out_valid,
  output logic [VEC_W-1:0] result
);

  localparam int SP_W     = 1 + SP_EXP_W + SP_FRAC_W;
  localparam int DP_W     = 1 + DP_EXP_W + DP_FRAC_W;
  localparam int SP_LANES = VEC_W / SP_W;
  localparam int DP_LANES = VEC_W / DP_W;

  logic [MASK_W-1:0] sel;
  logic [VEC_W-1:0]  sp_vec, dp_vec, next_res;
  logic              fmt_q;

  assign sel = {dc_top, dc_next, dc_low};

  for (genvar g = 0; g < SP_LANES; g++) begin : g_sp
    lane_class_t c;
    fpc_lane_classify #(.EXP_W(SP_EXP_W), .FRAC_W(SP_FRAC_W)) u_cls (
      .lane (src[g*SP_W +: SP_W]),
      .cls  (c)
    );
    fpc_lane_match #(.LANE_W(SP_W)) u_match (
      .cls      (c),
      .sel      (sel),
      .lane_out (sp_vec[g*SP_W +: SP_W])
    );
  end

  for (genvar g = 0; g < DP_LANES; g++) begin : g_dp
    lane_class_t c;
    fpc_lane_classify #(.EXP_W(DP_EXP_W), .FRAC_W(DP_FRAC_W)) u_cls (
      .lane (src[g*DP_W +: DP_W]),
      .cls  (c)
    );
    fpc_lane_match #(.LANE_W(DP_W)) u_match (
      .cls      (c),
      .sel      (sel),
      .lane_out (dp_vec[g*DP_W +: DP_W])
    );
  end

  assign next_res = fmt_dp ? dp_vec : sp_vec;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
      fmt_q     <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result <= next_res;
        fmt_q  <= fmt_dp;
      end
    end
  end

  // R10
  valid_rise_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  // R10
  valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  // R10
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(result));

  // R3
  for (genvar g = 0; g < SP_LANES; g++) begin : g_sp_chk
    sp_lane_uniform_chk: assert property (@(posedge clk) disable iff (rst)
      (out_valid && !fmt_q) |->
        (result[g*SP_W +: SP_W] == '0 || result[g*SP_W +: SP_W] == '1));
  end

  // R3
  for (genvar g = 0; g < DP_LANES; g++) begin : g_dp_chk
    dp_lane_uniform_chk: assert property (@(posedge clk) disable iff (rst)
      (out_valid && fmt_q) |->
        (result[g*DP_W +: DP_W] == '0 || result[g*DP_W +: DP_W] == '1));
  end

endmodule

// File: tb/fpc_vec_tester_test.sv
`timescale 1ns/1ps
module fpc_vec_tester_test;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic         fmt_dp = 1'b0;
  logic         dc_top = 1'b0;
  logic         dc_next = 1'b0;
  logic [4:0]   dc_low = '0;
  logic [127:0] src = '0;
  logic         out_valid;
  logic [127:0] result;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  fpc_vec_tester uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .fmt_dp(fmt_dp),
    .dc_top(dc_top), .dc_next(dc_next), .dc_low(dc_low), .src(src),
    .out_valid(out_valid), .result(result)
  );

  function automatic bit lane_hit(bit s, bit emax, bit ezero, bit fnz, logic [6:0] m);
    if (emax && fnz)   return m[6];            // R4
    if (emax)          return s ? m[4] : m[5]; // R5
    if (ezero && !fnz) return s ? m[2] : m[3]; // R6
    if (ezero)         return s ? m[0] : m[1]; // R7
    return 1'b0;                               // R8
  endfunction

  function automatic logic [127:0] model(logic [127:0] v, bit dp, logic [6:0] m);
    logic [127:0] r = '0;
    if (dp) begin
      for (int i = 0; i < 2; i++) begin
        logic [63:0] e = v[64*i +: 64];
        if (lane_hit(e[63], &e[62:52], ~|e[62:52], |e[51:0], m)) r[64*i +: 64] = '1;
      end
    end else begin
      for (int i = 0; i < 4; i++) begin
        logic [31:0] e = v[32*i +: 32];
        if (lane_hit(e[31], &e[30:23], ~|e[30:23], |e[22:0], m)) r[32*i +: 32] = '1;
      end
    end
    return r;
  endfunction

  function automatic logic [31:0] sp_kind(int k);
    case (k)
      0: return 32'h0000_0000; 1: return 32'h8000_0000;
      2: return 32'h7F80_0000; 3: return 32'hFF80_0000;
      4: return 32'h7FC0_0000; 5: return 32'hFF80_0001;
      6: return 32'h0000_0001; 7: return 32'h807F_FFFF;
      8: return 32'h3F80_0000; default: return 32'h8080_0000;
    endcase
  endfunction

  function automatic logic [63:0] dp_kind(int k);
    case (k)
      0: return 64'h0000_0000_0000_0000; 1: return 64'h8000_0000_0000_0000;
      2: return 64'h7FF0_0000_0000_0000; 3: return 64'hFFF0_0000_0000_0000;
      4: return 64'h7FF8_0000_0000_0000; 5: return 64'hFFF0_0000_0000_0001;
      6: return 64'h0000_0000_0000_0001; 7: return 64'h800F_FFFF_FFFF_FFFF;
      8: return 64'h3FF0_0000_0000_0000; default: return 64'h8010_0000_0000_0000;
    endcase
  endfunction

  task automatic check(bit ok, string tag, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply(logic [127:0] v, bit dp, logic [6:0] m);
    logic [127:0] exp = model(v, dp, m);
    @(negedge clk);
    src = v; fmt_dp = dp;
    {dc_top, dc_next, dc_low} = m;  // R9 field order
    in_valid = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b1 && result == exp, dp ? "R2" : "R1", result, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    int seed_dummy;
    logic [127:0] held;
    seed_dummy = $urandom(32'h5EED);

    repeat (3) @(negedge clk);
    // R11: reset state
    check(out_valid == 1'b0 && result == '0, "R11", result, '0);
    rst = 1'b0;

    // R1 R3-R8: all masks, every class in every SP lane position
    for (int rot = 0; rot < 10; rot++)
      for (int m = 0; m < 128; m++) begin
        logic [127:0] v;
        for (int i = 0; i < 4; i++) v[32*i +: 32] = sp_kind((rot + i) % 10);
        apply(v, 1'b0, m[6:0]);
      end

    // R2 R3-R8: all masks, every class in both DP lane positions
    for (int rot = 0; rot < 10; rot++)
      for (int m = 0; m < 128; m++) begin
        logic [127:0] v;
        for (int i = 0; i < 2; i++) v[64*i +: 64] = dp_kind((rot + 3*i) % 10);
        apply(v, 1'b1, m[6:0]);
      end

    // R9: NaN lanes with only the top field set give all ones
    apply({4{sp_kind(5)}}, 1'b0, 7'b100_0000);
    check(result == '1, "R9", result, '1);
    // R9: infinity with only dc_next set (positive infinity select)
    apply({2{dp_kind(2)}}, 1'b1, 7'b010_0000);
    check(result == '1, "R9", result, '1);

    // R10: idle cycle keeps result, drops out_valid
    held = result;
    @(negedge clk);
    in_valid = 1'b0;
    src = ~src;
    @(negedge clk);
    check(out_valid == 1'b0 && result == held, "R10", result, held);

    // random vectors with forced special exponents
    for (int n = 0; n < 2000; n++) begin
      logic [127:0] v;
      bit dp = $urandom_range(0, 1);
      v = {$urandom, $urandom, $urandom, $urandom};
      if (dp) begin
        for (int i = 0; i < 2; i++) begin
          int r = $urandom_range(0, 5);
          if (r == 0) v[64*i+52 +: 11] = '0;
          if (r == 1) v[64*i+52 +: 11] = '1;
          if (r == 2) v[64*i +: 52] = '0;
          if (r == 3) begin v[64*i+52 +: 11] = '1; v[64*i +: 52] = '0; end
        end
      end else begin
        for (int i = 0; i < 4; i++) begin
          int r = $urandom_range(0, 5);
          if (r == 0) v[32*i+23 +: 8] = '0;
          if (r == 1) v[32*i+23 +: 8] = '1;
          if (r == 2) v[32*i +: 23] = '0;
          if (r == 3) begin v[32*i+23 +: 8] = '0; v[32*i +: 23] = '0; end
        end
      end
      apply(v, dp, 7'($urandom));
    end

    // R11: mid-run reset clears a nonzero result
    apply({4{sp_kind(0)}}, 1'b0, 7'h7F);
    @(negedge clk);
    rst = 1'b1;
    in_valid = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0 && result == '0, "R11", result, '0);
    rst = 1'b0;
    in_valid = 1'b0;

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule